// File: doc/BRIEF.md
# Watchdog Timer with Selectable Time-Out Response

This block is a 16-bit down-counting watchdog. It runs from a slow, free-running oscillator of roughly 10 kHz, which is independent of the system clock. The oscillator level is brought into the system clock domain, and each of its rising edges becomes a single-cycle count enable. Software arms the watchdog by raising the enable input. It then keeps the watchdog alive with a refresh strobe, which copies the two-byte reload register back into the counter.

When the count reaches zero, the block either raises a system reset or sends an exception request to an interrupt controller. A static option input picks between the two. In exception mode the counter reloads by itself and keeps running.

A debug input holds the counter at its reload value, so a halted processor never sees a time-out. A stop input marks the low-power state: an exception-mode time-out in that state also raises a wake request. Two sticky status flags record what happened: one for any watchdog time-out and one for a wake from stop.

Top module: `wdg_top`

## Requirements
- R1: After a synchronous active-low reset, every output is 0, `count_o` is 0, and the reload register holds 0x0400.
- R2: When `enable` goes from low to high, the counter loads the reload value on the next clock. After that it decreases by one on each tick and holds its value between ticks.
- R3: One tick is produced for each rising edge of `osc_in`, after a two-flop synchronizer. An oscillator period of P system clocks therefore gives one decrement every P cycles.
- R4: A one-cycle `refresh` strobe while the watchdog is enabled reloads the counter from the reload register on the next clock edge.
- R5: `rld_we[1]` writes `rld_wdata` into the high byte of the reload value, and `rld_we[0]` writes it into the low byte; each byte lane is written independently. A reload value of 0x0000 means 65,536 ticks: the first tick after loading it moves the count to 0xFFFF with no time-out.
- R6: With `resp_sel`=1 (reset response), the tick that takes the count from 1 to 0 raises `wdt_reset_o` on the next clock. The output stays high until the clock edge of the next tick (one tick period), the counter reloads, and `stat_wdt_o` is set.
- R7: With `resp_sel`=0 (exception response), a time-out gives a one-cycle `exc_req_o` pulse and reloads the counter in the same edge. Counting then continues.
- R8: While `debug_mode` is high, the counter is reloaded on every clock, so no time-out occurs.
- R9: An exception-mode time-out while `stop_mode` is high also gives a one-cycle `wake_req_o` pulse together with `exc_req_o`, and sets both `stat_wdt_o` and `stat_stop_o`.
- R10: The status flags stay set until a `stat_clr` strobe or reset. A time-out in the same cycle as `stat_clr` wins, so the flag is set.
- R11: While `enable` is low, the counter is held at 0 and no reset, exception or wake output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| osc_in | input | 1 | Slow watchdog oscillator level (asynchronous) |
| enable | input | 1 | Watchdog armed |
| refresh | input | 1 | Software refresh strobe |
| rld_we | input | 2 | Reload byte write enables (bit 1 high byte, bit 0 low byte) |
| rld_wdata | input | 8 | Reload byte write data |
| resp_sel | input | 1 | Time-out response: 1 reset, 0 exception |
| debug_mode | input | 1 | Debug halt, continuous refresh |
| stop_mode | input | 1 | Device is in stop mode |
| stat_clr | input | 1 | Clear both status flags |
| wdt_reset_o | output | 1 | System reset request |
| exc_req_o | output | 1 | Exception request pulse |
| wake_req_o | output | 1 | Stop-mode recovery pulse |
| stat_wdt_o | output | 1 | Sticky watchdog time-out flag |
| stat_stop_o | output | 1 | Sticky stop-mode wake flag |
| count_o | output | 16 | Current counter value |

## Verification
The hardest case to reach is a time-out that lands on the same clock as a status clear. The expiry edge is fixed by the asynchronous oscillator and the synchronizer delay, so a single timed clear strobe would rarely hit it. The bench instead holds `stat_clr` high for the whole wait, with a short reload value. At the cycle where `exc_req_o` pulses, the flag must read 1, and one cycle later it must read 0. The 65,536-tick meaning of a zero reload is checked without running the full span: the bench watches the first tick take the count to 0xFFFF with no expiry.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the watchdog timer.
package wdg_pkg;
    localparam int WDG_CNT_W      = 16;
    localparam int WDG_LANE_W     = 8;
    localparam logic [WDG_CNT_W-1:0] WDG_RELOAD_RST = 16'h0400;

    // Time-out response option
    typedef enum logic {
        RESP_EXC = 1'b0,
        RESP_RST = 1'b1
    } wdg_resp_e;
endpackage

// File: rtl/wdg_tick_sync.sv
// Brings the slow oscillator level into the system clock domain and turns
// each rising edge into a one-cycle tick enable.
// Assumes the oscillator is much slower than clk (period >= 2 clk cycles).
module wdg_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic tick_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], osc_i};
            prev_q <= sync_q[LAST];
        end
    end

    // Rising edge of the synchronized level
    always_comb tick_o = sync_q[LAST] & ~prev_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3
endmodule

// File: rtl/wdg_reload_reg.sv
// Reload value register written one byte lane at a time.
// Assumes CNT_W is a multiple of LANE_W.
module wdg_reload_reg #(
    parameter int CNT_W   = wdg_pkg::WDG_CNT_W,
    parameter int LANE_W  = wdg_pkg::WDG_LANE_W,
    parameter logic [CNT_W-1:0] RST_VAL = wdg_pkg::WDG_RELOAD_RST
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CNT_W/LANE_W-1:0]       lane_we,
    input  logic [LANE_W-1:0]             wdata,
    output logic [CNT_W-1:0]              reload_o
);
    localparam int LANES = CNT_W / LANE_W;

    logic [CNT_W-1:0] val_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane of the reload value
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q[g*LANE_W +: LANE_W] <= RST_VAL[g*LANE_W +: LANE_W];
            else if (lane_we[g])
                val_q[g*LANE_W +: LANE_W] <= wdata;
        end

        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_we[g] |=> $stable(val_q[g*LANE_W +: LANE_W])); // R5
    end

    always_comb reload_o = val_q;
endmodule

// File: rtl/wdg_counter.sv
// Down counter: loads on first enable, reloads on refresh or debug,
// decrements on tick, and flags expiry on the tick that reaches zero.
// Both responses reload the counter at expiry. A reload of zero spans the
// whole counter range.
module wdg_counter #(
    parameter int CNT_W = wdg_pkg::WDG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             refresh,
    input  logic             debug_mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             reload_now;

    // Refresh sources once the counter is running
    always_comb reload_now = refresh | debug_mode;

    // Tick that brings the count from one to zero
    always_comb expire_o = enable & run_q & ~reload_now & tick & (cnt_q == ONE);

    // Counter state update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (!enable) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (!run_q) begin
            cnt_q <= reload_i;
            run_q <= 1'b1;
        end else if (reload_now || expire_o) begin
            cnt_q <= reload_i;
        end else if (tick) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    always_comb cnt_o = cnt_q;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && enable && !reload_now && !tick) |=> $stable(cnt_q)); // R2
    AST_DEBUG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && enable && debug_mode) |=> (cnt_q == $past(reload_i))); // R8
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/wdg_response.sv
// Turns an expiry into a reset hold, an exception pulse, a wake pulse and
// sticky status flags. The reset hold lasts until the next tick.
module wdg_response (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              tick,
    input  wdg_pkg::wdg_resp_e resp,
    input  logic              stop_mode,
    input  logic              stat_clr,
    output logic              rst_o,
    output logic              exc_o,
    output logic              wake_o,
    output logic              flag_wdt_o,
    output logic              flag_stop_o
);
    import wdg_pkg::*;

    logic rst_q, exc_q, wake_q, fw_q, fs_q;
    logic exc_now, wake_now;

    always_comb exc_now  = expire & (resp == RESP_EXC);
    always_comb wake_now = exc_now & stop_mode;

    // Reset request: set on expiry in reset mode, dropped on the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)                          rst_q <= 1'b0;
        else if (expire && resp == RESP_RST) rst_q <= 1'b1;
        else if (tick)                       rst_q <= 1'b0;
    end

    // Single-cycle exception and wake pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            exc_q  <= exc_now;
            wake_q <= wake_now;
        end
    end

    // Sticky status flags; a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fw_q <= 1'b0;
            fs_q <= 1'b0;
        end else begin
            if (expire)        fw_q <= 1'b1;
            else if (stat_clr) fw_q <= 1'b0;
            if (wake_now)      fs_q <= 1'b1;
            else if (stat_clr) fs_q <= 1'b0;
        end
    end

    always_comb begin
        rst_o       = rst_q;
        exc_o       = exc_q;
        wake_o      = wake_q;
        flag_wdt_o  = fw_q;
        flag_stop_o = fs_q;
    end

    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |=> !exc_q); // R7
    AST_WAKE_WITH_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (exc_q && fs_q && fw_q)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_q && !stat_clr) |=> fw_q); // R10
    AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && !tick) |=> rst_q); // R6
endmodule

// File: rtl/wdg_top.sv
// Watchdog timer top: oscillator tick synchronizer, byte-wide reload
// register, down counter and time-out response logic.
// Assumes resp_sel is static while the watchdog runs.
module wdg_top #(
    parameter int CNT_W       = wdg_pkg::WDG_CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_in,
    input  logic             enable,
    input  logic             refresh,
    input  logic [1:0]       rld_we,
    input  logic [7:0]       rld_wdata,
    input  logic             resp_sel,
    input  logic             debug_mode,
    input  logic             stop_mode,
    input  logic             stat_clr,
    output logic             wdt_reset_o,
    output logic             exc_req_o,
    output logic             wake_req_o,
    output logic             stat_wdt_o,
    output logic             stat_stop_o,
    output logic [CNT_W-1:0] count_o
);
    import wdg_pkg::*;

    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] reload;
    wdg_resp_e        resp;

    always_comb resp = wdg_resp_e'(resp_sel);

    wdg_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .osc_i(osc_in), .tick_o(tick)
    );

    wdg_reload_reg #(.CNT_W(CNT_W), .LANE_W(8)) u_reload (
        .clk(clk), .rst_n(rst_n), .lane_we(rld_we), .wdata(rld_wdata),
        .reload_o(reload)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .refresh(refresh),
        .debug_mode(debug_mode), .tick(tick), .reload_i(reload),
        .cnt_o(count_o), .expire_o(expire)
    );

    wdg_response u_resp (
        .clk(clk), .rst_n(rst_n), .expire(expire), .tick(tick), .resp(resp),
        .stop_mode(stop_mode), .stat_clr(stat_clr),
        .rst_o(wdt_reset_o), .exc_o(exc_req_o), .wake_o(wake_req_o),
        .flag_wdt_o(stat_wdt_o), .flag_stop_o(stat_stop_o)
    );

    AST_NO_OUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable)) |-> (!exc_req_o && !wake_req_o)); // R11
endmodule

// File: tb/tb_wdg_top.sv
// Self-checking bench with a behavioural cycle model compared every clock.
module tb_wdg_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_in = 1'b0;
    logic enable = 1'b0, refresh = 1'b0, resp_sel = 1'b1;
    logic debug_mode = 1'b0, stop_mode = 1'b0, stat_clr = 1'b0;
    logic [1:0] rld_we = 2'b00;
    logic [7:0] rld_wdata = 8'h00;
    logic wdt_reset_o, exc_req_o, wake_req_o, stat_wdt_o, stat_stop_o;
    logic [15:0] count_o;

    int n_chk = 0, n_bad = 0, cyc = 0, half = 2, osc_cnt = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_top dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .enable(enable),
        .refresh(refresh), .rld_we(rld_we), .rld_wdata(rld_wdata),
        .resp_sel(resp_sel), .debug_mode(debug_mode), .stop_mode(stop_mode),
        .stat_clr(stat_clr), .wdt_reset_o(wdt_reset_o), .exc_req_o(exc_req_o),
        .wake_req_o(wake_req_o), .stat_wdt_o(stat_wdt_o),
        .stat_stop_o(stat_stop_o), .count_o(count_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Oscillator: toggles every 'half' clocks
    always @(negedge clk) begin
        if (osc_cnt >= half - 1) begin
            osc_in  <= ~osc_in;
            osc_cnt <= 0;
        end else osc_cnt <= osc_cnt + 1;
    end

    // Behavioural reference model
    int oq[$] = '{0, 0, 0};
    int m_cnt = 0, m_rld = 'h400, m_run = 0;
    int m_rst = 0, m_exc = 0, m_wake = 0, m_sw = 0, m_ss = 0;

    always @(posedge clk) begin
        int tk, ex, old_rld;
        cyc++;
        if (!rst_n) begin
            oq = '{0, 0, 0};
            m_cnt = 0; m_rld = 'h400; m_run = 0;
            m_rst = 0; m_exc = 0; m_wake = 0; m_sw = 0; m_ss = 0;
        end else begin
            tk = (oq[1] == 1 && oq[2] == 0) ? 1 : 0;
            ex = 0;
            old_rld = m_rld;
            if (!enable) begin m_run = 0; m_cnt = 0; end
            else if (m_run == 0) begin m_run = 1; m_cnt = old_rld; end
            else if (refresh || debug_mode) m_cnt = old_rld;
            else if (tk == 1) begin
                if (m_cnt == 1) begin ex = 1; m_cnt = old_rld; end
                else m_cnt = (m_cnt - 1) & 'hFFFF;
            end
            m_exc  = (ex == 1 && !resp_sel) ? 1 : 0;
            m_wake = (m_exc == 1 && stop_mode) ? 1 : 0;
            if (ex == 1 && resp_sel) m_rst = 1;
            else if (tk == 1) m_rst = 0;
            if (ex == 1) m_sw = 1; else if (stat_clr) m_sw = 0;
            if (m_wake == 1) m_ss = 1; else if (stat_clr) m_ss = 0;
            if (rld_we[1]) m_rld = (m_rld & 'h00FF) | (int'(rld_wdata) << 8);
            if (rld_we[0]) m_rld = (m_rld & 'hFF00) | int'(rld_wdata);
            oq.push_front(int'(osc_in));
            void'(oq.pop_back());
        end
    end

    // Compare every output with the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2", "count", int'(count_o), m_cnt);
            chk("R6", "reset", int'(wdt_reset_o), m_rst);
            chk("R7", "exc", int'(exc_req_o), m_exc);
            chk("R9", "wake", int'(wake_req_o), m_wake);
            chk("R10", "flag_wdt", int'(stat_wdt_o), m_sw);
            chk("R10", "flag_stop", int'(stat_stop_o), m_ss);
        end
    end

    // Watchdog for a hung run
    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_for_exc(int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (exc_req_o) return;
        end
    endtask

    task automatic wr_reload(int hi, int lo);
        @(negedge clk); rld_we = 2'b10; rld_wdata = 8'(hi);
        @(negedge clk); rld_we = 2'b01; rld_wdata = 8'(lo);
        @(negedge clk); rld_we = 2'b00;
    endtask

    task automatic do_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    initial begin
        int held, seen, c0;
        cycles(3);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1: reset state
        chk("R1", "reset out", int'(wdt_reset_o), 0);
        chk("R1", "exc out", int'(exc_req_o | wake_req_o), 0);
        chk("R1", "count", int'(count_o), 0);
        // R1/R2: first enable loads default reload
        enable = 1'b1;
        @(negedge clk);
        chk("R1", "default reload", int'(count_o), 'h400);
        cycles(20);
        chk("R2", "counting down", int'(count_o < 16'h400), 1);

        // R3: one decrement per oscillator period
        c0 = int'(count_o); cycles(40);
        chk("R3", "ticks in 40 cycles", c0 - int'(count_o), 10);
        half = 3;
        cycles(8);
        c0 = int'(count_o); cycles(60);
        chk("R3", "ticks in 60 cycles", c0 - int'(count_o), 10);
        half = 2;

        // R4/R5: byte writes then refresh
        wr_reload(8'h00, 8'h05);
        do_refresh();
        chk("R4", "refresh load", int'(count_o), 5);

        // R6: reset response
        resp_sel = 1'b1;
        for (int i = 0; i < 200 && !wdt_reset_o; i++) @(negedge clk);
        chk("R6", "reset raised", int'(wdt_reset_o), 1);
        chk("R6", "flag set", int'(stat_wdt_o), 1);
        chk("R6", "reload after", int'(count_o), 5);
        held = 0;
        while (wdt_reset_o && held < 100) begin held++; @(negedge clk); end
        chk("R6", "reset held cycles", held, 4);

        // R10: clear
        stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
        chk("R10", "flag cleared", int'(stat_wdt_o), 0);

        // R7: exception response
        resp_sel = 1'b0;
        wait_for_exc(200);
        chk("R7", "exc pulse", int'(exc_req_o), 1);
        chk("R7", "auto reload", int'(count_o), 5);
        chk("R7", "no wake", int'(wake_req_o), 0);
        @(negedge clk);
        chk("R7", "exc single", int'(exc_req_o), 0);
        chk("R7", "no reset", int'(wdt_reset_o), 0);

        // R9: stop-mode time-out
        stop_mode = 1'b1;
        wait_for_exc(200);
        chk("R9", "wake pulse", int'(wake_req_o), 1);
        chk("R9", "stop flag", int'(stat_stop_o), 1);
        chk("R9", "wdt flag", int'(stat_wdt_o), 1);
        stop_mode = 1'b0;

        // R10: set wins over a simultaneous clear
        stat_clr = 1'b1;
        cycles(2);
        chk("R10", "flags cleared", int'(stat_wdt_o | stat_stop_o), 0);
        wait_for_exc(200);
        chk("R10", "set beats clear", int'(stat_wdt_o), 1);
        @(negedge clk);
        chk("R10", "cleared after", int'(stat_wdt_o), 0);
        stat_clr = 1'b0;

        // R8: debug holds off time-outs
        debug_mode = 1'b1;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (exc_req_o) seen++;
        end
        chk("R8", "no exc in debug", seen, 0);
        chk("R8", "count held", int'(count_o), 5);
        debug_mode = 1'b0;

        // R5: zero reload spans 65536 ticks
        wr_reload(8'h00, 8'h00);
        do_refresh();
        chk("R5", "zero loaded", int'(count_o), 0);
        seen = 0;
        for (int i = 0; i < 20 && count_o == 16'h0000; i++) begin
            @(negedge clk);
            if (exc_req_o) seen++;
        end
        chk("R5", "wrap to FFFF", int'(count_o), 'hFFFF);
        chk("R5", "no expiry at zero", seen + int'(exc_req_o), 0);

        // R5: high byte written alone
        @(negedge clk); rld_we = 2'b10; rld_wdata = 8'h01;
        @(negedge clk); rld_we = 2'b00;
        do_refresh();
        chk("R5", "high lane only", int'(count_o), 'h0100);

        // R11: disable
        enable = 1'b0;
        @(negedge clk);
        chk("R11", "count cleared", int'(count_o), 0);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (exc_req_o || wdt_reset_o || wake_req_o) seen++;
        end
        chk("R11", "silent when off", seen, 0);
        chk("R11", "count stays 0", int'(count_o), 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R2", "re-enable load", int'(count_o), 'h0100);
        cycles(10);

        cmp_on = 0;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule